// File: doc/BRIEF.md
# Oscillator Enable Control Register

This block is the software-facing control word for two clock sources of a chip: an on-die RC oscillator and an external crystal oscillator. Software turns each source on or off and programs a five-bit trim value. Hardware events have the last word. Waking from a low-power mode, or a failure of the crystal while it feeds the system clock, forces the RC source on. Entering a low-power mode turns the crystal off. A source that is feeding the system clock cannot be turned off by software.

The block also reports when the RC source is stable. The oscillator clock reaches the block as a one-cycle tick pulse in the register clock domain, one pulse per oscillator period. A state machine counts these ticks to raise the ready flag after a warm-up and to drop it only after a wind-down once the source is disabled. A factory calibration byte is captured once after reset and added to the trim field to give a nine-bit effective trim code for the analog oscillator.

The ready tracker has four states. RDY_OFF goes to RDY_WARM when the enable is high. RDY_WARM goes to RDY_ON after the warm-up tick count, or back to RDY_OFF if the enable drops first. RDY_ON goes to RDY_COOL when the enable drops. RDY_COOL goes to RDY_OFF after the wind-down tick count, or back to RDY_ON on re-enable. The calibration loader has two states. CAL_LOAD captures the input on the first cycle after reset, then moves to CAL_HOLD, where it stays.

Top module: `osc_enable_ctrl`

## Requirements
- R1: The read word holds the RC enable in bit 0, the RC ready flag in bit 1, zero in bit 2, the trim field in bits 7:3, the calibration byte in bits 15:8, the crystal enable in bit 16 and zero in bits 31:17. A write ignores bits 1, 2, 15:8 and 31:17.
- R2: A `lp_enter` pulse clears the crystal enable on the next clock edge. This holds even if a write in the same cycle sets bit 16, and even while the crystal feeds the system clock.
- R3: A write with bit 16 at 0 leaves the crystal enable set while `sysclk_uses_ext` is high. Otherwise bit 16 of a write becomes the crystal enable.
- R4: The RC enable is set on the next edge by `lp_exit`, or by `ext_fail` while `sysclk_uses_ext` is high. This overrides a write of 0 in the same cycle. `ext_fail` has no effect while `sysclk_uses_ext` is low.
- R5: A write with bit 0 at 0 leaves the RC enable set while `sysclk_uses_rc` is high.
- R6: The ready flag rises after WARM_TICKS (default 4) `rc_tick` pulses are seen by the tracker while the enable stays high. The tracker sees the enable one cycle after the register changes. If the enable drops first, the count restarts from zero.
- R7: After the RC enable is cleared, the ready flag stays high until FALL_TICKS (default 6) tick pulses have been seen. A re-enable during this wind-down keeps the flag high.
- R8: The trim field resets to 16. `trim_eff` equals the trim field plus the calibration byte, nine bits wide, so the largest value is 286.
- R9: The calibration byte is captured from `cal_in` on the first clock after reset. Later changes of `cal_in`, and writes to bits 15:8, do not alter it.
- R10: During reset the RC enable is 1, the crystal enable is 0, the ready flag is 0, the trim field is 16 and the calibration byte is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Full-word write strobe |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Register read value |
| cal_in | input | 8 | Factory calibration byte |
| rc_tick | input | 1 | One pulse per RC oscillator period |
| lp_enter | input | 1 | Stop or standby entry event |
| lp_exit | input | 1 | Stop or standby exit event |
| ext_fail | input | 1 | Crystal failure detected |
| sysclk_uses_ext | input | 1 | Crystal drives the system clock, directly or indirectly |
| sysclk_uses_rc | input | 1 | RC drives, or is selected to become, the system clock |
| rc_en | output | 1 | Enable to the RC oscillator |
| ext_en | output | 1 | Enable to the crystal oscillator |
| rc_ready | output | 1 | RC oscillator stable |
| trim_eff | output | 9 | Effective trim code, trim plus calibration |

## Verification
Writes, hardware events and the calibration capture show at the ports one clock edge after the input is presented, because each lands in a register at that edge. The ready flag lags further. The tracker first sees a new enable value one edge after the enable register changes, and then needs the stated number of tick pulses. A behavioural model in the bench applies the same rules with the same one-edge lags and is compared against every output at each falling edge. Directed checks sample at fixed cycle counts after each stimulus, chosen from those lags. The tick input is also driven at half rate so that ticks and cycles are counted apart.

// File: rtl/osc_ctrl_pkg.sv
package osc_ctrl_pkg;

    localparam int REG_W      = 32;
    localparam int POS_RC_EN  = 0;
    localparam int POS_RC_RDY = 1;
    localparam int POS_RSVD   = 2;
    localparam int TRIM_LSB   = 3;
    localparam int CAL_LSB    = 8;
    localparam int POS_EXT_EN = 16;

    typedef enum logic [1:0] {
        RDY_OFF,
        RDY_WARM,
        RDY_ON,
        RDY_COOL
    } rdy_state_t;

    typedef enum logic {
        CAL_LOAD,
        CAL_HOLD
    } cal_state_t;

    typedef struct packed {
        logic rc_set;
        logic ext_clr;
    } hw_evt_t;

endpackage

// File: rtl/osc_enable_logic.sv
module osc_enable_logic
    import osc_ctrl_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    wr_en,
    input  logic    wr_rc,
    input  logic    wr_ext,
    input  hw_evt_t evt,
    input  logic    lock_rc,
    input  logic    lock_ext,
    output logic    rc_en,
    output logic    ext_en
);

    logic rc_next;
    logic ext_next;

    // Priority, lowest first: hold, software write, hardware event.
    always_comb begin
        rc_next = rc_en;
        if (wr_en) begin
            rc_next = wr_rc | (rc_en & lock_rc);
        end
        if (evt.rc_set) begin
            rc_next = 1'b1;
        end
    end

    always_comb begin
        ext_next = ext_en;
        if (wr_en) begin
            ext_next = wr_ext | (ext_en & lock_ext);
        end
        if (evt.ext_clr) begin
            ext_next = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rc_en  <= 1'b1;
            ext_en <= 1'b0;
        end else begin
            rc_en  <= rc_next;
            ext_en <= ext_next;
        end
    end

endmodule

// File: rtl/osc_ready_tracker.sv
module osc_ready_tracker
    import osc_ctrl_pkg::*;
#(
    parameter int WARM_TICKS = 4,
    parameter int FALL_TICKS = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic tick,
    output logic ready
);

    localparam int MAX_TICKS = (WARM_TICKS > FALL_TICKS) ? WARM_TICKS : FALL_TICKS;
    localparam int CNT_W     = $clog2(MAX_TICKS + 1);
    localparam logic [CNT_W-1:0] WARM_LAST = CNT_W'(WARM_TICKS - 1);
    localparam logic [CNT_W-1:0] FALL_LAST = CNT_W'(FALL_TICKS - 1);

    rdy_state_t       state_q;
    rdy_state_t       state_d;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RDY_OFF;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            RDY_OFF: begin
                if (enable) begin
                    state_d = RDY_WARM;
                    cnt_d   = '0;
                end
            end
            RDY_WARM: begin
                if (!enable) begin
                    state_d = RDY_OFF;
                    cnt_d   = '0;
                end else if (tick) begin
                    if (cnt_q == WARM_LAST) begin
                        state_d = RDY_ON;
                        cnt_d   = '0;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
            end
            RDY_ON: begin
                if (!enable) begin
                    state_d = RDY_COOL;
                    cnt_d   = '0;
                end
            end
            RDY_COOL: begin
                if (enable) begin
                    state_d = RDY_ON;
                    cnt_d   = '0;
                end else if (tick) begin
                    if (cnt_q == FALL_LAST) begin
                        state_d = RDY_OFF;
                        cnt_d   = '0;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
            end
            default: begin
                state_d = RDY_OFF;
                cnt_d   = '0;
            end
        endcase
    end

    always_comb begin
        unique case (state_q)
            RDY_ON, RDY_COOL: ready = 1'b1;
            default:          ready = 1'b0;
        endcase
    end

endmodule

// File: rtl/osc_trim_unit.sv
module osc_trim_unit
    import osc_ctrl_pkg::*;
#(
    parameter int TRIM_W     = 5,
    parameter int CAL_W      = 8,
    parameter int TRIM_RESET = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [TRIM_W-1:0]     wr_trim,
    input  logic [CAL_W-1:0]      cal_in,
    output logic [TRIM_W-1:0]     trim,
    output logic [CAL_W-1:0]      cal,
    output logic [CAL_W:0]        trim_eff
);

    localparam int SUM_W = ((TRIM_W > CAL_W) ? TRIM_W : CAL_W) + 1;

    cal_state_t cal_state_q;
    cal_state_t cal_state_d;
    logic       cal_capture;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cal_state_q <= CAL_LOAD;
        end else begin
            cal_state_q <= cal_state_d;
        end
    end

    always_comb begin
        cal_state_d = cal_state_q;
        cal_capture = 1'b0;
        unique case (cal_state_q)
            CAL_LOAD: begin
                cal_capture = 1'b1;
                cal_state_d = CAL_HOLD;
            end
            CAL_HOLD: begin
                cal_state_d = CAL_HOLD;
            end
            default: begin
                cal_state_d = CAL_LOAD;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cal <= '0;
        end else if (cal_capture) begin
            cal <= cal_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            trim <= TRIM_W'(TRIM_RESET);
        end else if (wr_en) begin
            trim <= wr_trim;
        end
    end

    logic [SUM_W-1:0] sum;
    assign sum      = SUM_W'(trim) + SUM_W'(cal);
    assign trim_eff = (CAL_W + 1)'(sum);

endmodule

// File: rtl/osc_enable_ctrl.sv
module osc_enable_ctrl
    import osc_ctrl_pkg::*;
#(
    parameter int WARM_TICKS = 4,
    parameter int FALL_TICKS = 6,
    parameter int TRIM_RESET = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [31:0] wr_data,
    output logic [31:0] rd_data,
    input  logic [7:0]  cal_in,
    input  logic        rc_tick,
    input  logic        lp_enter,
    input  logic        lp_exit,
    input  logic        ext_fail,
    input  logic        sysclk_uses_ext,
    input  logic        sysclk_uses_rc,
    output logic        rc_en,
    output logic        ext_en,
    output logic        rc_ready,
    output logic [8:0]  trim_eff
);

    localparam int TRIM_W = CAL_LSB - TRIM_LSB;
    localparam int CAL_W  = POS_EXT_EN - CAL_LSB;

    hw_evt_t           evt;
    logic [TRIM_W-1:0] trim;
    logic [CAL_W-1:0]  cal;
    logic              unused_wr_bits;

    assign evt.rc_set  = lp_exit | (ext_fail & sysclk_uses_ext);
    assign evt.ext_clr = lp_enter;

    assign unused_wr_bits = ^{wr_data[REG_W-1:POS_EXT_EN+1],
                              wr_data[POS_EXT_EN-1:CAL_LSB],
                              wr_data[POS_RSVD:POS_RC_RDY]};

    osc_enable_logic u_enable (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_rc    (wr_data[POS_RC_EN]),
        .wr_ext   (wr_data[POS_EXT_EN]),
        .evt      (evt),
        .lock_rc  (sysclk_uses_rc),
        .lock_ext (sysclk_uses_ext),
        .rc_en    (rc_en),
        .ext_en   (ext_en)
    );

    osc_ready_tracker #(
        .WARM_TICKS (WARM_TICKS),
        .FALL_TICKS (FALL_TICKS)
    ) u_ready (
        .clk    (clk),
        .rst_n  (rst_n),
        .enable (rc_en),
        .tick   (rc_tick),
        .ready  (rc_ready)
    );

    osc_trim_unit #(
        .TRIM_W     (TRIM_W),
        .CAL_W      (CAL_W),
        .TRIM_RESET (TRIM_RESET)
    ) u_trim (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_trim  (wr_data[CAL_LSB-1:TRIM_LSB]),
        .cal_in   (cal_in),
        .trim     (trim),
        .cal      (cal),
        .trim_eff (trim_eff)
    );

    always_comb begin
        rd_data                         = '0;
        rd_data[POS_RC_EN]              = rc_en;
        rd_data[POS_RC_RDY]             = rc_ready;
        rd_data[CAL_LSB-1:TRIM_LSB]     = trim;
        rd_data[POS_EXT_EN-1:CAL_LSB]   = cal;
        rd_data[POS_EXT_EN]             = ext_en;
    end

endmodule

// File: rtl/osc_enable_ctrl_chk.sv
module osc_enable_ctrl_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [31:0] rd_data,
    input logic        lp_enter,
    input logic        lp_exit,
    input logic        ext_fail,
    input logic        sysclk_uses_ext,
    input logic        sysclk_uses_rc,
    input logic        rc_en,
    input logic        ext_en,
    input logic        rc_ready,
    input logic [8:0]  trim_eff
);

    assert_reserved_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data[2] == 1'b0) && (rd_data[31:17] == '0));

    assert_lp_enter_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
        lp_enter |=> !ext_en);

    assert_ext_locked_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (sysclk_uses_ext && ext_en && !lp_enter) |=> ext_en);

    assert_rc_forced_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (lp_exit || (ext_fail && sysclk_uses_ext)) |=> rc_en);

    assert_rc_locked_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rc_en && sysclk_uses_rc) |=> rc_en);

    assert_ready_rise_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rc_ready) |-> $past(rc_en));

    assert_ready_fall_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rc_ready) |-> !$past(rc_en));

    assert_trim_sum_R8: assert property (@(posedge clk) disable iff (!rst_n)
        trim_eff == ({4'b0, rd_data[7:3]} + {1'b0, rd_data[15:8]}));

endmodule

bind osc_enable_ctrl osc_enable_ctrl_chk u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .rd_data         (rd_data),
    .lp_enter        (lp_enter),
    .lp_exit         (lp_exit),
    .ext_fail        (ext_fail),
    .sysclk_uses_ext (sysclk_uses_ext),
    .sysclk_uses_rc  (sysclk_uses_rc),
    .rc_en           (rc_en),
    .ext_en          (ext_en),
    .rc_ready        (rc_ready),
    .trim_eff        (trim_eff)
);

// File: tb/osc_enable_ctrl_tb.sv
module osc_enable_ctrl_tb;

    localparam int CLK_PERIOD = 10;
    localparam int WARM = 4;
    localparam int FALL = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic [7:0]  cal_in = 8'hA5;
    logic        rc_tick = 1'b1;
    logic        lp_enter = 1'b0;
    logic        lp_exit = 1'b0;
    logic        ext_fail = 1'b0;
    logic        sysclk_uses_ext = 1'b0;
    logic        sysclk_uses_rc = 1'b0;
    logic        rc_en;
    logic        ext_en;
    logic        rc_ready;
    logic [8:0]  trim_eff;

    int total = 0;
    int bad = 0;
    bit tick_half = 1'b0;
    bit done = 1'b0;

    // reference model state
    bit       m_rc = 1'b1;
    bit       m_ext = 1'b0;
    bit       m_rdy = 1'b0;
    int       m_phase = 0;
    int       m_cnt = 0;
    bit [4:0] m_trim = 5'd16;
    bit [7:0] m_cal = 8'h00;
    bit       m_loaded = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    osc_enable_ctrl u_dut (
        .clk             (clk),
        .rst_n           (rst_n),
        .wr_en           (wr_en),
        .wr_data         (wr_data),
        .rd_data         (rd_data),
        .cal_in          (cal_in),
        .rc_tick         (rc_tick),
        .lp_enter        (lp_enter),
        .lp_exit         (lp_exit),
        .ext_fail        (ext_fail),
        .sysclk_uses_ext (sysclk_uses_ext),
        .sysclk_uses_rc  (sysclk_uses_rc),
        .rc_en           (rc_en),
        .ext_en          (ext_en),
        .rc_ready        (rc_ready),
        .trim_eff        (trim_eff)
    );

    always @(negedge clk) begin
        if (tick_half) rc_tick <= ~rc_tick;
        else           rc_tick <= 1'b1;
    end

    // behavioural model, evaluated on each rising edge
    always @(posedge clk) begin
        if (!rst_n) begin
            m_rc = 1'b1; m_ext = 1'b0; m_rdy = 1'b0; m_phase = 0; m_cnt = 0;
            m_trim = 5'd16; m_cal = 8'h00; m_loaded = 1'b0;
        end else begin
            bit old_rc;
            old_rc = m_rc;
            if (m_phase == 0) begin
                if (old_rc) begin m_phase = 1; m_cnt = 0; end
            end else if (m_phase == 1) begin
                if (!old_rc) begin m_phase = 0; m_cnt = 0; end
                else if (rc_tick) begin
                    m_cnt++;
                    if (m_cnt == WARM) begin m_phase = 2; m_cnt = 0; end
                end
            end else if (m_phase == 2) begin
                if (!old_rc) begin m_phase = 3; m_cnt = 0; end
            end else begin
                if (old_rc) begin m_phase = 2; m_cnt = 0; end
                else if (rc_tick) begin
                    m_cnt++;
                    if (m_cnt == FALL) begin m_phase = 0; m_cnt = 0; end
                end
            end
            m_rdy = (m_phase >= 2);
            if (!m_loaded) begin m_cal = cal_in; m_loaded = 1'b1; end
            if (wr_en) begin
                m_trim = wr_data[7:3];
                if (!(sysclk_uses_rc && m_rc)) m_rc = wr_data[0];
                if (!(sysclk_uses_ext && m_ext)) m_ext = wr_data[16];
            end
            if (lp_exit || (ext_fail && sysclk_uses_ext)) m_rc = 1'b1;
            if (lp_enter) m_ext = 1'b0;
        end
    end

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (!done) begin
            bit [31:0] exp_rd;
            exp_rd = {15'b0, m_ext, m_cal, m_trim, 1'b0, m_rdy, m_rc};
            check(rd_data == exp_rd, "R1 rd_data", rd_data, exp_rd);
            check(rc_en == m_rc, "R4 rc_en", rc_en, m_rc);
            check(ext_en == m_ext, "R3 ext_en", ext_en, m_ext);
            check(rc_ready == m_rdy, "R6 rc_ready", rc_ready, m_rdy);
            check(trim_eff == 9'(m_trim) + 9'(m_cal), "R8 trim_eff", trim_eff,
                  9'(m_trim) + 9'(m_cal));
        end
    end

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
        #1;
    endtask

    task automatic wr(input logic [31:0] d);
        wr_en = 1'b1; wr_data = d;
        cyc(1);
        wr_en = 1'b0; wr_data = '0;
    endtask

    initial begin
        for (int i = 0; i < 20000; i++) @(posedge clk);
        bad++;
        total++;
        done = 1'b1;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #1;
        cyc(3);
        // R10 reset values
        check(rd_data == 32'h0000_0081, "R10 reset word", rd_data, 32'h81);
        check(trim_eff == 9'd16, "R10 reset trim_eff", trim_eff, 16);
        rst_n = 1'b1;
        cyc(8);
        check(rc_ready == 1'b1, "R6 ready after warm-up", rc_ready, 1);
        check(rd_data == 32'h0000_A583, "R9 cal captured", rd_data, 32'hA583);

        cal_in = 8'h3C;
        wr(32'hFFFE_00FD);
        check(rd_data == 32'h0000_A5FB, "R1 read-only bits ignored", rd_data, 32'hA5FB);
        check(trim_eff == 9'd196, "R8 sum", trim_eff, 196);
        cyc(2);
        check(rd_data[15:8] == 8'hA5, "R9 cal held", rd_data[15:8], 8'hA5);

        sysclk_uses_rc = 1'b1;
        wr(32'h0000_0080);
        check(rc_en == 1'b1, "R5 clear refused", rc_en, 1);
        sysclk_uses_rc = 1'b0;
        tick_half = 1'b1;
        wr(32'h0000_0080);
        check(rc_en == 1'b0, "R5 clear accepted when free", rc_en, 0);
        cyc(3);
        check(rc_ready == 1'b1, "R7 ready held during wind-down", rc_ready, 1);
        cyc(20);
        check(rc_ready == 1'b0, "R7 ready dropped", rc_ready, 0);

        wr(32'h0001_0080);
        sysclk_uses_ext = 1'b1;
        wr(32'h0000_0080);
        check(ext_en == 1'b1, "R3 ext clear refused", ext_en, 1);
        sysclk_uses_ext = 1'b0;
        ext_fail = 1'b1;
        cyc(1);
        ext_fail = 1'b0;
        check(rc_en == 1'b0, "R4 fail ignored when ext not in use", rc_en, 0);
        sysclk_uses_ext = 1'b1;
        ext_fail = 1'b1;
        wr(32'h0000_0080);
        ext_fail = 1'b0;
        check(rc_en == 1'b1, "R4 fail forces rc on", rc_en, 1);
        lp_enter = 1'b1;
        wr(32'h0001_0081);
        lp_enter = 1'b0;
        check(ext_en == 1'b0, "R2 lp entry clears ext", ext_en, 0);
        sysclk_uses_ext = 1'b0;
        wr(32'h0000_0080);
        cyc(2);
        lp_exit = 1'b1;
        wr(32'h0000_0080);
        lp_exit = 1'b0;
        check(rc_en == 1'b1, "R4 wake forces rc on", rc_en, 1);

        tick_half = 1'b0;
        cyc(2);
        wr(32'h0000_0080);
        cyc(15);
        check(rc_ready == 1'b0, "R7 off before abort test", rc_ready, 0);
        wr(32'h0000_0081);
        cyc(2);
        wr(32'h0000_0080);
        wr(32'h0000_0081);
        cyc(3);
        check(rc_ready == 1'b0, "R6 warm count restarted", rc_ready, 0);
        cyc(3);
        check(rc_ready == 1'b1, "R6 ready after restart", rc_ready, 1);
        wr(32'h0000_0080);
        cyc(2);
        wr(32'h0000_0081);
        cyc(10);
        check(rc_ready == 1'b1, "R7 re-enable keeps ready", rc_ready, 1);

        cal_in = 8'hFF;
        rst_n = 1'b0;
        cyc(2);
        rst_n = 1'b1;
        cyc(1);
        wr(32'h0000_00F9);
        check(trim_eff == 9'd286, "R8 max sum", trim_eff, 286);
        check(rd_data[15:8] == 8'hFF, "R9 cal after second reset", rd_data[15:8], 8'hFF);
        cyc(4);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule